// File: doc/BRIEF.md
# Debug ROM Entry Slot Sequencer

This block serves the small memory-mapped region that halted harts fetch from while they sit in debug mode. The region holds one entry word for each hart, two code words, and one exception word for each hart. A halted hart normally spins on its entry word, which holds a jump to itself. The block answers fetches from a single memory port. It also updates the busy flag, the per-hart halted flags and the error code from what it sees the harts fetch.

The command controller launches work in one of two ways. A command launch loads two generated instruction words into the code area. It turns the selected hart's entry word into a jump to the code area, points that hart's exception word back at its entry word, and sets busy. A resume request loads the return-from-debug instruction into the first code word and patches the entry word in the same way. Once the hart has fetched the patched entry word, the next valid fetch outside the entry window puts the self-jump back. When the hart later returns to a self-jump, busy clears.

The address layout is set by three base parameters. Every jump is formed with the offset computed from those bases.

Top module: `dbg_slot_seq`

## Requirements
- R1: After reset, busy is 0, the halted mask is 0, every entry word and every exception word reads 0x0000006F (a jump to x0 with offset 0), and both code words read 0.
- R2: A valid fetch of entry word n (byte address ENTRY_BASE + 4n) sets bit n of the halted mask.
- R3: A fetch of the selected hart's entry word while it holds the self-jump clears busy. A fetch of any other hart's entry word leaves busy unchanged.
- R4: A fetch of the selected hart's entry word while it holds a patched jump returns that jump and leaves busy set. The next valid fetch outside the entry window restores the word to 0x0000006F, and entry-window fetches in between do not restore it.
- R5: launchCmd loads cmdWord0 and cmdWord1 into code words 0 and 1 (byte addresses CODE_BASE and CODE_BASE + 4). It writes into entry word n, for n equal to hartSel, a jump with offset CODE_BASE - (ENTRY_BASE + 4n), and it sets busy on the next cycle.
- R6: launchCmd writes into exception word n (byte address EXC_BASE + 4n), for n equal to hartSel, a jump with offset (ENTRY_BASE + 4n) - EXC_BASE.
- R7: resumeReq loads 0x7B200073 into code word 0, patches the selected entry word as in R5, and sets busy.
- R8: A fetch from the code area while code word 0 holds 0x7B200073 clears busy and clears halted bit hartSel. With any other value in code word 0, a code fetch changes neither.
- R9: A fetch from the exception window pulses errUpdValid, with errUpdCode = 3, only when cmdErrIn is 0. Otherwise errUpdValid stays 0.
- R10: A fetch that is misaligned (address bits 1:0 not 0) or lies outside all three windows returns respErr = 1 with data 0. It leaves busy, the halted mask, the words and any pending restore unchanged.
- R11: respValid, respData and respErr follow a fetch by exactly one cycle. respData is the word as it stood before the same cycle's update.
- R12: Jump words put offset bit 20 at bit 31, offset bits 10:1 at bits 30:21, offset bit 11 at bit 20 and offset bits 19:12 at bits 19:12, with rd = 0 in bits 11:7 and 0x6F in bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hartSel | input | HART_W | Currently selected hart |
| fetchValid | input | 1 | Fetch request |
| fetchAddr | input | ADDR_W | Byte address within the region |
| launchCmd | input | 1 | Launch strobe from the controller |
| cmdWord0 | input | 32 | Generated instruction for code word 0 |
| cmdWord1 | input | 32 | Generated instruction for code word 1 |
| resumeReq | input | 1 | Resume strobe from the controller |
| cmdErrIn | input | 3 | Error code currently held by the controller |
| respValid | output | 1 | Fetch response valid |
| respData | output | 32 | Fetched word |
| respErr | output | 1 | Fetch hit no window |
| busy | output | 1 | A command or resume is in flight |
| haltedMask | output | NUM_HARTS | Per-hart halted flags |
| errUpdValid | output | 1 | Request to record an exception error |
| errUpdCode | output | 3 | Error code to record (3) |

## Verification
Every fetch result (data, error flag, error update) and every status change it causes appears on the outputs one clock after the fetch is presented. A patch or restore only shows in the data of the next fetch after that. The bench drives each request on a falling edge, lets one rising edge pass, and samples on the following falling edge. Strobes from the controller are checked the same way, one edge after they are applied. The restore rule is checked by fetching the patched word twice and by placing error fetches between the patched fetch and the next entry fetch, so a restore that comes too early shows up as a self-jump.

// File: rtl/dbg_slot_pkg.sv
package dbg_slot_pkg;

  localparam logic [31:0] SELF_JUMP = 32'h0000006F;
  localparam logic [31:0] DRET_WORD = 32'h7B200073;
  localparam logic [2:0]  ERR_EXC   = 3'd3;

  typedef enum logic [1:0] {
    REG_NONE,
    REG_ENTRY,
    REG_CODE,
    REG_EXC
  } region_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    patchEntry;
    logic    patchExc;
    logic    loadCode;
    logic    loadDret;
    logic    restore;
    logic    readEn;
    region_e rdRegion;
  } dpCtl_t;

  // jump to x0, J-type immediate layout
  function automatic logic [31:0] jumpWord(input logic [31:0] off);
    return {off[20], off[10:1], off[11], off[19:12], 5'd0, 7'h6F};
  endfunction

endpackage

// File: rtl/dbg_slot_ctrl.sv
module dbg_slot_ctrl
  import dbg_slot_pkg::*;
#(
  parameter int NUM_HARTS  = 4,
  parameter int ADDR_W     = 12,
  parameter int ENTRY_BASE = 256,
  parameter int CODE_BASE  = 768,
  parameter int EXC_BASE   = 512,
  localparam int HART_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [HART_W-1:0]    hartSel,
  input  logic                 fetchValid,
  input  logic [ADDR_W-1:0]    fetchAddr,
  input  logic                 launchCmd,
  input  logic                 resumeReq,
  input  logic [2:0]           cmdErrIn,
  input  logic                 selSelf,
  input  logic                 codeDret,
  output dpCtl_t               ctl,
  output logic [HART_W-1:0]    rdIdx,
  output logic                 respValid,
  output logic                 respErr,
  output logic                 busy,
  output logic [NUM_HARTS-1:0] haltedMask,
  output logic                 errUpdValid
);

  localparam logic [31:0] ENT_LO  = 32'(ENTRY_BASE);
  localparam logic [31:0] ENT_HI  = 32'(ENTRY_BASE + 4 * NUM_HARTS);
  localparam logic [31:0] CODE_LO = 32'(CODE_BASE);
  localparam logic [31:0] CODE_HI = 32'(CODE_BASE + 8);
  localparam logic [31:0] EXC_LO  = 32'(EXC_BASE);
  localparam logic [31:0] EXC_HI  = 32'(EXC_BASE + 4 * NUM_HARTS);

  logic [31:0]          addrW;
  region_e              region;
  logic                 hit;
  logic                 actQ, actD;
  logic                 busyD;
  logic [NUM_HARTS-1:0] haltD, haltSet, haltClr;
  logic                 selEntry;

  // address decode
  always_comb begin
    addrW  = 32'(fetchAddr);
    region = REG_NONE;
    rdIdx  = '0;
    if (addrW[1:0] == 2'b00) begin
      if (addrW >= ENT_LO && addrW < ENT_HI) begin
        region = REG_ENTRY;
        rdIdx  = HART_W'((addrW - ENT_LO) >> 2);
      end else if (addrW >= CODE_LO && addrW < CODE_HI) begin
        region = REG_CODE;
        rdIdx  = HART_W'((addrW - CODE_LO) >> 2);
      end else if (addrW >= EXC_LO && addrW < EXC_HI) begin
        region = REG_EXC;
        rdIdx  = HART_W'((addrW - EXC_LO) >> 2);
      end
    end
  end

  assign hit      = fetchValid && (region != REG_NONE);
  assign selEntry = hit && (region == REG_ENTRY) && (rdIdx == hartSel);

  always_comb begin
    ctl.patchEntry = launchCmd | resumeReq;
    ctl.patchExc   = launchCmd;
    ctl.loadCode   = launchCmd;
    ctl.loadDret   = resumeReq & ~launchCmd;
    ctl.restore    = hit && (region != REG_ENTRY) && actQ;
    ctl.readEn     = hit;
    ctl.rdRegion   = region;

    haltSet = '0;
    haltClr = '0;
    if (hit && region == REG_ENTRY)
      haltSet = NUM_HARTS'(1) << rdIdx;
    if (hit && region == REG_CODE && codeDret)
      haltClr = NUM_HARTS'(1) << hartSel;
    haltD = (haltedMask & ~haltClr) | haltSet;

    if (launchCmd || resumeReq)
      busyD = 1'b1;
    else if ((selEntry && selSelf) || (hit && region == REG_CODE && codeDret))
      busyD = 1'b0;
    else
      busyD = busy;

    if (selEntry && !selSelf)
      actD = 1'b1;
    else if (ctl.restore)
      actD = 1'b0;
    else
      actD = actQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy        <= 1'b0;
      haltedMask  <= '0;
      actQ        <= 1'b0;
      respValid   <= 1'b0;
      respErr     <= 1'b0;
      errUpdValid <= 1'b0;
    end else begin
      busy        <= busyD;
      haltedMask  <= haltD;
      actQ        <= actD;
      respValid   <= fetchValid;
      respErr     <= fetchValid && (region == REG_NONE);
      errUpdValid <= hit && (region == REG_EXC) && (cmdErrIn == 3'd0);
    end
  end

endmodule

// File: rtl/dbg_slot_dp.sv
module dbg_slot_dp
  import dbg_slot_pkg::*;
#(
  parameter int NUM_HARTS  = 4,
  parameter int ENTRY_BASE = 256,
  parameter int CODE_BASE  = 768,
  parameter int EXC_BASE   = 512,
  localparam int HART_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HART_W-1:0] hartSel,
  input  dpCtl_t            ctl,
  input  logic [HART_W-1:0] rdIdx,
  input  logic [31:0]       cmdWord0,
  input  logic [31:0]       cmdWord1,
  output logic              selSelf,
  output logic              codeDret,
  output logic [31:0]       respData
);

  logic [31:0] entryQ [NUM_HARTS];
  logic [31:0] excQ   [NUM_HARTS];
  logic [31:0] code0Q, code1Q;
  logic [31:0] rdWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_HARTS; i++) begin
        entryQ[i] <= SELF_JUMP;
        excQ[i]   <= SELF_JUMP;
      end
      code0Q <= '0;
      code1Q <= '0;
    end else begin
      for (int i = 0; i < NUM_HARTS; i++) begin
        if (HART_W'(i) == hartSel) begin
          if (ctl.patchEntry)
            entryQ[i] <= jumpWord(32'(CODE_BASE - (ENTRY_BASE + 4 * i)));
          else if (ctl.restore)
            entryQ[i] <= SELF_JUMP;
          if (ctl.patchExc)
            excQ[i] <= jumpWord(32'((ENTRY_BASE + 4 * i) - EXC_BASE));
        end
      end
      if (ctl.loadCode) begin
        code0Q <= cmdWord0;
        code1Q <= cmdWord1;
      end else if (ctl.loadDret) begin
        code0Q <= DRET_WORD;
      end
    end
  end

  always_comb begin
    selSelf = 1'b0;
    for (int i = 0; i < NUM_HARTS; i++)
      if (HART_W'(i) == hartSel) selSelf = (entryQ[i] == SELF_JUMP);
    codeDret = (code0Q == DRET_WORD);
  end

  always_comb begin
    rdWord = '0;
    for (int i = 0; i < NUM_HARTS; i++) begin
      if (HART_W'(i) == rdIdx) begin
        if (ctl.rdRegion == REG_ENTRY) rdWord = entryQ[i];
        if (ctl.rdRegion == REG_EXC)   rdWord = excQ[i];
      end
    end
    if (ctl.rdRegion == REG_CODE) rdWord = rdIdx[0] ? code1Q : code0Q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) respData <= '0;
    else       respData <= ctl.readEn ? rdWord : 32'd0;
  end

endmodule

// File: rtl/dbg_slot_seq.sv
module dbg_slot_seq
  import dbg_slot_pkg::*;
#(
  parameter int NUM_HARTS  = 4,
  parameter int ADDR_W     = 12,
  parameter int ENTRY_BASE = 256,
  parameter int CODE_BASE  = 768,
  parameter int EXC_BASE   = 512,
  localparam int HART_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [HART_W-1:0]    hartSel,
  input  logic                 fetchValid,
  input  logic [ADDR_W-1:0]    fetchAddr,
  input  logic                 launchCmd,
  input  logic [31:0]          cmdWord0,
  input  logic [31:0]          cmdWord1,
  input  logic                 resumeReq,
  input  logic [2:0]           cmdErrIn,
  output logic                 respValid,
  output logic [31:0]          respData,
  output logic                 respErr,
  output logic                 busy,
  output logic [NUM_HARTS-1:0] haltedMask,
  output logic                 errUpdValid,
  output logic [2:0]           errUpdCode
);

  dpCtl_t            ctl;
  logic [HART_W-1:0] rdIdx;
  logic              selSelf, codeDret;

  assign errUpdCode = ERR_EXC;

  dbg_slot_ctrl #(
    .NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W), .ENTRY_BASE(ENTRY_BASE),
    .CODE_BASE(CODE_BASE), .EXC_BASE(EXC_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hartSel(hartSel), .fetchValid(fetchValid),
    .fetchAddr(fetchAddr), .launchCmd(launchCmd), .resumeReq(resumeReq),
    .cmdErrIn(cmdErrIn), .selSelf(selSelf), .codeDret(codeDret), .ctl(ctl),
    .rdIdx(rdIdx), .respValid(respValid), .respErr(respErr), .busy(busy),
    .haltedMask(haltedMask), .errUpdValid(errUpdValid)
  );

  dbg_slot_dp #(
    .NUM_HARTS(NUM_HARTS), .ENTRY_BASE(ENTRY_BASE),
    .CODE_BASE(CODE_BASE), .EXC_BASE(EXC_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hartSel(hartSel), .ctl(ctl), .rdIdx(rdIdx),
    .cmdWord0(cmdWord0), .cmdWord1(cmdWord1), .selSelf(selSelf),
    .codeDret(codeDret), .respData(respData)
  );

endmodule

// File: rtl/dbg_slot_chk.sv
module dbg_slot_chk #(
  parameter int NUM_HARTS  = 4,
  parameter int ADDR_W     = 12,
  parameter int ENTRY_BASE = 256
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 fetchValid,
  input logic [ADDR_W-1:0]    fetchAddr,
  input logic                 launchCmd,
  input logic                 resumeReq,
  input logic [2:0]           cmdErrIn,
  input logic                 respValid,
  input logic                 respErr,
  input logic                 busy,
  input logic [NUM_HARTS-1:0] haltedMask,
  input logic                 errUpdValid
);

  AST_BUSY_ON_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (launchCmd || resumeReq) |=> busy); // R5

  AST_HALT_ENTRY0: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchAddr == ADDR_W'(ENTRY_BASE)) |=> haltedMask[0]); // R2

  AST_BAD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchAddr[1:0] != 2'b00 && !launchCmd && !resumeReq)
      |=> (respErr && $stable(busy) && $stable(haltedMask))); // R10

  AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    errUpdValid |-> ($past(cmdErrIn) == 3'd0)); // R9

  AST_RESP_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |=> respValid); // R11

  AST_RESP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |=> !respValid); // R11

endmodule

bind dbg_slot_seq dbg_slot_chk #(
  .NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W), .ENTRY_BASE(ENTRY_BASE)
) u_chk (.*);

// File: tb/dbg_slot_seq_tb.sv
module dbg_slot_seq_tb;

  localparam int N  = 4;
  localparam int EB = 256;
  localparam int CB = 768;
  localparam int XB = 512;
  localparam logic [31:0] SELF = 32'h0000006F;
  localparam logic [31:0] DRET = 32'h7B200073;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  hartSel = '0;
  logic        fetchValid = 1'b0;
  logic [11:0] fetchAddr = '0;
  logic        launchCmd = 1'b0;
  logic [31:0] cmdWord0 = '0, cmdWord1 = '0;
  logic        resumeReq = 1'b0;
  logic [2:0]  cmdErrIn = '0;
  logic        respValid, respErr, busy, errUpdValid;
  logic [31:0] respData;
  logic [N-1:0] haltedMask;
  logic [2:0]  errUpdCode;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dbg_slot_seq u_dut (
    .clk(clk), .rstN(rstN), .hartSel(hartSel), .fetchValid(fetchValid),
    .fetchAddr(fetchAddr), .launchCmd(launchCmd), .cmdWord0(cmdWord0),
    .cmdWord1(cmdWord1), .resumeReq(resumeReq), .cmdErrIn(cmdErrIn),
    .respValid(respValid), .respData(respData), .respErr(respErr),
    .busy(busy), .haltedMask(haltedMask), .errUpdValid(errUpdValid),
    .errUpdCode(errUpdCode)
  );

  function automatic logic [31:0] expJump(input int off);
    logic [20:0] im;
    im = 21'(off);
    return {im[20], im[10:1], im[11], im[19:12], 12'h06F};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fetch(input int a);
    @(negedge clk);
    fetchValid = 1'b1;
    fetchAddr  = 12'(a);
    @(negedge clk);
    fetchValid = 1'b0;
  endtask

  task automatic launch(input logic [31:0] w0, input logic [31:0] w1);
    @(negedge clk);
    cmdWord0 = w0; cmdWord1 = w1; launchCmd = 1'b1;
    @(negedge clk);
    launchCmd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busy at reset", 32'(busy), 0);
    chk("R1 halted at reset", 32'(haltedMask), 0);
    chk("R11 no response idle", 32'(respValid), 0);

    fetch(XB);
    chk("R1 exception word reset", respData, SELF);
    chk("R9 exception update when clean", 32'(errUpdValid), 1);
    chk("R9 update code", 32'(errUpdCode), 3);
    fetch(CB);
    chk("R1 code word reset", respData, 0);
    chk("R8 code fetch non-dret keeps busy", 32'(busy), 0);

    for (int h = 0; h < N; h++) begin
      fetch(EB + 4 * h);
      chk("R1 entry word reset", respData, SELF);
      chk("R2 halted bit set", 32'(haltedMask[h]), 1);
      chk("R11 response valid", 32'(respValid), 1);
      chk("R11 no error", 32'(respErr), 0);
    end

    for (int h = 0; h < N; h++) begin
      hartSel = 2'(h);
      launch(32'hA000_0000 | 32'(h), 32'hB000_0000 | 32'(h));
      chk("R5 busy after launch", 32'(busy), 1);
      fetch(XB + 4 * h);
      chk("R6 exception jump", respData, expJump(EB + 4 * h - XB));
      fetch(EB + 4 * h);
      chk("R5 R12 entry jump", respData, expJump(CB - (EB + 4 * h)));
      chk("R4 busy held on patched fetch", 32'(busy), 1);
      fetch(EB + 4 * h);
      chk("R4 no restore by entry fetch", respData, expJump(CB - (EB + 4 * h)));
      fetch(CB);
      chk("R5 code word 0", respData, 32'hA000_0000 | 32'(h));
      fetch(CB + 4);
      chk("R5 code word 1", respData, 32'hB000_0000 | 32'(h));
      fetch(EB + 4 * h);
      chk("R4 slot restored", respData, SELF);
      chk("R3 busy cleared", 32'(busy), 0);
    end

    cmdErrIn = 3'd2;
    fetch(XB + 4);
    chk("R9 no update when error held", 32'(errUpdValid), 0);
    cmdErrIn = 3'd0;

    hartSel = 2'd0;
    launch(32'h1234_5678, 32'h9ABC_DEF0);
    fetch(EB + 12);
    chk("R3 other hart entry keeps busy", 32'(busy), 1);
    fetch(CB);
    chk("R8 non-dret code keeps busy", 32'(busy), 1);
    chk("R8 non-dret code keeps halted", 32'(haltedMask), 32'hF);
    fetch(EB);
    chk("R4 patched word returned", respData, expJump(CB - EB));
    fetch(EB + 1);
    chk("R10 misaligned error", 32'(respErr), 1);
    chk("R10 misaligned data", respData, 0);
    chk("R10 busy unchanged", 32'(busy), 1);
    fetch(4);
    chk("R10 outside window error", 32'(respErr), 1);
    chk("R10 halted unchanged", 32'(haltedMask), 32'hF);
    fetch(EB);
    chk("R10 pending restore kept", respData, expJump(CB - EB));
    fetch(CB + 4);
    fetch(EB);
    chk("R4 restore after code fetch", respData, SELF);
    chk("R3 busy cleared hart0", 32'(busy), 0);

    hartSel = 2'd1;
    @(negedge clk);
    resumeReq = 1'b1;
    @(negedge clk);
    resumeReq = 1'b0;
    chk("R7 busy after resume", 32'(busy), 1);
    fetch(EB + 4);
    chk("R7 entry jump on resume", respData, expJump(CB - (EB + 4)));
    fetch(CB);
    chk("R7 dret loaded", respData, DRET);
    chk("R8 dret fetch clears busy", 32'(busy), 0);
    chk("R8 dret fetch clears halted", 32'(haltedMask), 32'hD);
    fetch(EB + 4);
    chk("R4 restored after resume", respData, SELF);
    chk("R2 halted again", 32'(haltedMask), 32'hF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule